// File: doc/BRIEF.md
# Debug Capture Trace Buffer with Fill Counter

This block records 20-bit capture words into a 64-line circular memory while a debug session is armed. A 6-bit fill count tracks how many lines hold valid data, and a separate full flag records that the count has wrapped at least once. Software arms a session through a small control port. Arming clears the count and the flag. Software then reads the two status bytes and drains the stored lines, oldest first, through a read port.

Two alignment modes decide what happens when the memory fills. In begin-aligned mode the session ends on the 64th capture and the oldest data is kept. In end-aligned mode capture goes on, and each new word overwrites the oldest line.

Power-on reset and system reset are separate inputs. System reset ends the session and rewinds the read pointer. It leaves the count, the flag and the stored lines untouched, so a session cut short by a system reset can still be inspected.

The session controller has three states:
- IDLE: not armed.
- FILL: armed, memory not yet full.
- RING: armed, end-aligned mode, memory full and overwriting.

Its transitions are:
- ARM: an arm write of one moves IDLE, FILL or RING to FILL.
- DISARM: an arm write of zero goes to IDLE.
- STOP: the wrapping capture in begin-aligned mode moves FILL to IDLE.
- WRAP: the wrapping capture in end-aligned mode moves FILL to RING.
- SYSRST: a system reset sends any state to IDLE.

Top module: `trace_fill_buf`

## Requirements
- R1: While `por_n` is low, `stat_cnt`, `stat_sr` and `rd_data` all read zero, and the session is not armed.
- R2: Each capture strobe taken while armed does two things. It writes `cap_data` to line index equal to the current count, and it increments the 6-bit count, which reads in `stat_cnt[5:0]`.
- R3: A capture strobe while not armed changes neither the count, nor the full flag, nor the stored lines.
- R4: An arm write (`ctl_we`=1, `ctl_arm`=1) clears the count and the full flag. It latches `ctl_mode_end` (0 = begin-aligned, 1 = end-aligned). A capture strobe in the same cycle is dropped.
- R5: The capture that takes the count from 63 to 0 sets the full flag in `stat_cnt[7]`. `stat_cnt[6]` always reads zero.
- R6: In begin-aligned mode the capture that sets the full flag also ends the session. Later capture strobes are ignored, and the count stays 0 with the flag set.
- R7: In end-aligned mode the session continues after the full flag is set. The count keeps incrementing and each new word overwrites the oldest line.
- R8: Read order starts at the oldest line: index 0 when the full flag is clear, or index equal to the count when it is set. Each `rd_stb` loads the current line into `rd_data` one cycle later and advances the read pointer. `rd_rewind` returns it to the oldest line. Reads never change the count.
- R9: While `sys_rst_n` is low, the session is forced to IDLE, the read pointer is rewound, and arm writes and capture strobes are ignored. The count, the full flag and the stored lines are kept.
- R10: `stat_sr[7]` mirrors the full flag, `stat_sr[0]` shows whether a session is armed, and bits 6 to 1 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low |
| ctl_we | input | 1 | Control write strobe |
| ctl_arm | input | 1 | Arm value written with `ctl_we` |
| ctl_mode_end | input | 1 | Alignment mode written with `ctl_we`: 0 begin, 1 end |
| cap_stb | input | 1 | Capture strobe |
| cap_data | input | 20 | Capture word |
| rd_stb | input | 1 | Read one line and advance |
| rd_rewind | input | 1 | Return the read pointer to the oldest line |
| rd_data | output | 20 | Last line read |
| stat_cnt | output | 8 | {full, 0, count[5:0]} |
| stat_sr | output | 8 | {full, 000000, armed} |

## Verification
The properties assume that `ctl_we`, `cap_stb` and `rd_stb` are clean single-cycle levels sampled at the clock edge. They also assume that `por_n` is low from time zero, so that every property is gated until the first power-on release. The directed stimulus follows these assumptions: inputs change only on the falling edge, and power-on reset is held for several cycles at the start. The stimulus also drives capture strobes during a system reset and in the same cycle as an arm write. These are the input conditions under which the counter-hold properties must still hold.

// File: rtl/trace_fill_pkg.sv
package trace_fill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RING = 2'd2
    } sess_st_e;
endpackage

// File: rtl/trace_sess_fsm.sv
module trace_sess_fsm
    import trace_fill_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_n,
    input  logic arm_wr,
    input  logic arm_val,
    input  logic mode_val,
    input  logic cap_stb,
    input  logic wrap_hit,
    output logic armed,
    output logic mode_end,
    output logic cap_en,
    output logic clr
);
    sess_st_e st_q, st_d;
    logic     mode_q;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q   <= ST_IDLE;
            mode_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (arm_wr) begin
                mode_q <= mode_val;
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!sys_rst_n) begin
            st_d = ST_IDLE;                         // SYSRST
        end else if (arm_wr) begin
            st_d = arm_val ? ST_FILL : ST_IDLE;     // ARM / DISARM
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_FILL: begin
                    if (cap_stb && wrap_hit) begin
                        st_d = mode_q ? ST_RING : ST_IDLE;   // WRAP / STOP
                    end
                end
                ST_RING: st_d = ST_RING;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        armed    = (st_q != ST_IDLE);
        mode_end = mode_q;
        cap_en   = armed && cap_stb && sys_rst_n && !arm_wr;
        clr      = arm_wr && arm_val;
    end
endmodule

// File: rtl/trace_fill_ctr.sv
module trace_fill_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] cnt,
    output logic              full,
    output logic              wrap_hit
);
    localparam logic [ADDR_W-1:0] CNT_TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] cnt_q;
    logic              full_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_TOP) begin
                full_q <= 1'b1;
            end
        end
    end

    assign cnt      = cnt_q;
    assign full     = full_q;
    assign wrap_hit = (cnt_q == CNT_TOP);
endmodule

// File: rtl/trace_line_mem.sv
module trace_line_mem #(
    parameter int LINE_W = 20,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LINE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LINE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LINE_W-1:0] line_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (we && (waddr == ADDR_W'(g))) begin
                line_q[g] <= wdata;
            end
        end
    end

    assign rdata = line_q[raddr];
endmodule

// File: rtl/trace_fill_buf.sv
module trace_fill_buf
    import trace_fill_pkg::*;
#(
    parameter int LINE_W = 20,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              ctl_we,
    input  logic              ctl_arm,
    input  logic              ctl_mode_end,
    input  logic              cap_stb,
    input  logic [LINE_W-1:0] cap_data,
    input  logic              rd_stb,
    input  logic              rd_rewind,
    output logic [LINE_W-1:0] rd_data,
    output logic [7:0]        stat_cnt,
    output logic [7:0]        stat_sr
);
    localparam int PAD_W = 7 - ADDR_W;

    logic              arm_wr;
    logic              armed, mode_end, cap_en, clr;
    logic [ADDR_W-1:0] cnt_q;
    logic              full_q, wrap_hit;
    logic [ADDR_W-1:0] rd_ofs_q, oldest, rd_addr;
    logic [LINE_W-1:0] mem_rdata;
    logic [LINE_W-1:0] rd_data_q;

    assign arm_wr = ctl_we && sys_rst_n;

    trace_sess_fsm u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .sys_rst_n(sys_rst_n),
        .arm_wr   (arm_wr),
        .arm_val  (ctl_arm),
        .mode_val (ctl_mode_end),
        .cap_stb  (cap_stb),
        .wrap_hit (wrap_hit),
        .armed    (armed),
        .mode_end (mode_end),
        .cap_en   (cap_en),
        .clr      (clr)
    );

    trace_fill_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .por_n   (por_n),
        .clr     (clr),
        .inc     (cap_en),
        .cnt     (cnt_q),
        .full    (full_q),
        .wrap_hit(wrap_hit)
    );

    trace_line_mem #(.LINE_W(LINE_W), .ADDR_W(ADDR_W)) u_mem (
        .clk  (clk),
        .we   (cap_en),
        .waddr(cnt_q),
        .wdata(cap_data),
        .raddr(rd_addr),
        .rdata(mem_rdata)
    );

    // read side: offset from the oldest line
    assign oldest  = full_q ? cnt_q : '0;
    assign rd_addr = oldest + rd_ofs_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rd_ofs_q  <= '0;
            rd_data_q <= '0;
        end else if (!sys_rst_n || clr || rd_rewind) begin
            rd_ofs_q <= '0;
        end else if (rd_stb) begin
            rd_data_q <= mem_rdata;
            rd_ofs_q  <= rd_ofs_q + 1'b1;
        end
    end

    assign rd_data  = rd_data_q;
    assign stat_cnt = {full_q, {PAD_W{1'b0}}, cnt_q};
    assign stat_sr  = {full_q, 6'b0, armed};
endmodule

// File: rtl/trace_fill_chk.sv
module trace_fill_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic              ctl_we,
    input logic              ctl_arm,
    input logic              cap_stb,
    input logic              rd_stb,
    input logic [ADDR_W-1:0] cnt_q,
    input logic              full_q,
    input logic              armed,
    input logic              mode_end
);
    // R2: armed capture advances the count by one
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!por_n)
        (armed && cap_stb && !ctl_we && sys_rst_n) |=> (cnt_q == ADDR_W'($past(cnt_q) + 1'b1)));

    // R3: strobe while disarmed leaves count and flag
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!armed && cap_stb && !ctl_we) |=> ($stable(cnt_q) && $stable(full_q)));

    // R4: arm write clears count and flag
    p_arm_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
        (ctl_we && ctl_arm && sys_rst_n) |=> (cnt_q == '0 && !full_q));

    // R5: wrapping capture sets the flag
    p_full_set_r5: assert property (@(posedge clk) disable iff (!por_n)
        (armed && cap_stb && !ctl_we && sys_rst_n && cnt_q == '1) |=> full_q);

    // R6: a begin-aligned session is never armed with the flag set
    p_begin_stop_r6: assert property (@(posedge clk) disable iff (!por_n)
        (armed && !mode_end) |-> !full_q);

    // R7: end-aligned session stays armed once full
    p_ring_keep_r7: assert property (@(posedge clk) disable iff (!por_n)
        (armed && mode_end && full_q && cap_stb && !ctl_we && sys_rst_n) |=> (armed && full_q));

    // R8: reads do not change the count
    p_read_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        (rd_stb && !cap_stb && !ctl_we) |=> $stable(cnt_q));

    // R9: system reset keeps count and flag, ends session
    p_sysrst_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n) |=> ($stable(cnt_q) && $stable(full_q) && !armed));
endmodule

bind trace_fill_buf trace_fill_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .por_n    (por_n),
    .sys_rst_n(sys_rst_n),
    .ctl_we   (ctl_we),
    .ctl_arm  (ctl_arm),
    .cap_stb  (cap_stb),
    .rd_stb   (rd_stb),
    .cnt_q    (cnt_q),
    .full_q   (full_q),
    .armed    (armed),
    .mode_end (mode_end)
);

// File: tb/trace_fill_buf_tb_top.sv
module trace_fill_buf_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        ctl_we = 1'b0, ctl_arm = 1'b0, ctl_mode_end = 1'b0;
    logic        cap_stb = 1'b0;
    logic [19:0] cap_data = '0;
    logic        rd_stb = 1'b0, rd_rewind = 1'b0;
    logic [19:0] rd_data;
    logic [7:0]  stat_cnt, stat_sr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    trace_fill_buf dut_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .ctl_we(ctl_we), .ctl_arm(ctl_arm), .ctl_mode_end(ctl_mode_end),
        .cap_stb(cap_stb), .cap_data(cap_data),
        .rd_stb(rd_stb), .rd_rewind(rd_rewind), .rd_data(rd_data),
        .stat_cnt(stat_cnt), .stat_sr(stat_sr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic arm(input bit val, input bit mode_end);
        @(negedge clk);
        ctl_we = 1'b1; ctl_arm = val; ctl_mode_end = mode_end;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic capture(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap_stb = 1'b1; cap_data = 20'(base + i);
        end
        @(negedge clk);
        cap_stb = 1'b0;
    endtask

    // read n lines from oldest; expect base+first+k
    task automatic read_all(input int n, input int base, input string req);
        @(negedge clk);
        rd_rewind = 1'b1;
        @(negedge clk);
        rd_rewind = 1'b0;
        for (int k = 0; k < n; k++) begin
            rd_stb = 1'b1;
            @(negedge clk);
            rd_stb = 1'b0;
            chk(rd_data == 20'(base + k), req, int'(rd_data), base + k);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        // R1
        chk(stat_cnt == 8'h00, "R1", stat_cnt, 0);
        chk(stat_sr == 8'h00, "R1", stat_sr, 0);
        chk(rd_data == 20'h0, "R1", rd_data, 0);
    endtask

    task automatic t_disarmed;
        capture(3, 20'h111);
        chk(stat_cnt == 8'h00, "R3", stat_cnt, 0);
    endtask

    task automatic t_basic;
        arm(1'b1, 1'b0);
        chk(stat_sr == 8'h01, "R10", stat_sr, 1);
        capture(10, 20'h10000);
        chk(stat_cnt == 8'd10, "R2", stat_cnt, 10);
        read_all(10, 20'h10000, "R8");
        chk(stat_cnt == 8'd10, "R8", stat_cnt, 10);
    endtask

    task automatic t_collide;
        @(negedge clk);
        ctl_we = 1'b1; ctl_arm = 1'b1; ctl_mode_end = 1'b0;
        cap_stb = 1'b1; cap_data = 20'hDEAD0;
        @(negedge clk);
        ctl_we = 1'b0; cap_stb = 1'b0;
        chk(stat_cnt == 8'h00, "R4", stat_cnt, 0);
        capture(1, 20'h22222);
        read_all(1, 20'h22222, "R4");
    endtask

    task automatic t_begin_full;
        arm(1'b1, 1'b0);
        capture(64, 20'h30000);
        chk(stat_cnt == 8'h80, "R5", stat_cnt, 8'h80);
        chk(stat_sr == 8'h80, "R6", stat_sr, 8'h80);
        capture(2, 20'h3F000);
        chk(stat_cnt == 8'h80, "R6", stat_cnt, 8'h80);
        read_all(64, 20'h30000, "R8");
    endtask

    task automatic t_end_ring;
        arm(1'b1, 1'b1);
        chk(stat_cnt == 8'h00, "R4", stat_cnt, 0);
        capture(70, 20'h40000);
        chk(stat_cnt == 8'h86, "R7", stat_cnt, 8'h86);
        chk(stat_sr == 8'h81, "R10", stat_sr, 8'h81);
        read_all(64, 20'h40006, "R7");
    endtask

    task automatic t_sysrst;
        arm(1'b1, 1'b1);
        capture(5, 20'h50000);
        @(negedge clk);
        sys_rst_n = 1'b0; cap_stb = 1'b1; cap_data = 20'hBAD00;
        ctl_we = 1'b1; ctl_arm = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sys_rst_n = 1'b1; cap_stb = 1'b0; ctl_we = 1'b0;
        chk(stat_cnt == 8'd5, "R9", stat_cnt, 5);
        chk(stat_sr == 8'h00, "R9", stat_sr, 0);
        read_all(5, 20'h50000, "R9");
        capture(2, 20'h5F000);
        chk(stat_cnt == 8'd5, "R3", stat_cnt, 5);
    endtask

    task automatic t_por;
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        chk(stat_cnt == 8'h00, "R1", stat_cnt, 0);
        chk(stat_sr == 8'h00, "R1", stat_sr, 0);
        por_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        por_n = 1'b1;
        t_disarmed();
        t_basic();
        t_collide();
        t_begin_full();
        t_end_ring();
        t_sysrst();
        t_por();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule